// File: doc/BRIEF.md
# Microcoded Clarke/Park Transform Unit

This unit converts motor-control quantities between the three-phase frame, the stationary two-axis frame and the rotating two-axis frame. It runs forward and reverse Clarke transforms and forward and reverse Park transforms. There is no dedicated hardware for each transform. One multiplier and one adder/subtractor are shared by all of them, driven by a short microprogram held in a 45-word ROM with 12-bit words. An eight-entry register file stages the operands and holds the intermediate results.

A neighbouring block places up to four Q1.15 words on the inputs and picks a routine with a 3-bit selector. It then pulses `start` while `ready` is high. The unit captures the operands, lowers `ready`, and steps through the routine, taking two cycles per microinstruction. When the routine's end word executes, `ready` rises again and the results stay on the outputs until the next accepted start. Sine and cosine of the rotor angle are supplied from outside on inputs 3 and 4.

Top module: `clarke_park_unit`

## Requirements
- R1: After reset, `ready` is 1 and all four outputs are 0.
- R2: `start` is taken only on a rising edge where `ready` is 1, and `ready` is 0 after that edge. A `start` seen while `ready` is 0 has no effect, including on the edge where the routine ends.
- R3: For select codes 0 to 3, `ready` returns to 1 exactly 18 cycles after the edge that accepted the start. For codes 4 to 7 it returns after 2 cycles, with all four outputs 0.
- R4: All outputs are cleared to 0 on the accepting edge. An output that the routine does not write stays 0. While `ready` is 1, every output holds its value.
- R5: Arithmetic works on Q1.15 values. A product is floor(x*y / 2^15), and every product, sum, difference and negation is clamped to [-32768, 32767] before it is stored.
- R6: Code 0 is the forward Clarke transform, with a, b, c on x1, x2, x3. It computes u = sat(sat(a-b) + sat(a-c)) and gives y1 = u*10923 (one third), y2 = sat(b-c)*18919 (1/sqrt3).
- R7: Code 1 is the reverse Clarke transform, with alpha on x1 and beta on x2. With h = alpha*16384 and s = beta*28378 (sqrt3/2), it gives y1 = alpha, y2 = sat(s-h) and y3 = sat(sat(-h) - s).
- R8: Code 2 is the forward Park transform, with alpha, beta, sin and cos on x1 to x4. It gives y1 = sat(alpha*cos + beta*sin) and y2 = sat(beta*cos - alpha*sin).
- R9: Code 3 is the reverse Park transform, with d, q, sin and cos on x1 to x4. It gives y1 = sat(d*cos - q*sin) and y2 = sat(d*sin + q*cos).
- R10: Operands are captured on the accepting edge. Changing the inputs or the selector while `ready` is 0 does not change the results.
- R11: Each microinstruction takes one fetch cycle followed by one execute cycle, and the microprogram counter never leaves the 45-word ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the selected routine |
| alg_sel | input | 3 | Routine select (0 fwd Clarke, 1 rev Clarke, 2 fwd Park, 3 rev Park) |
| in_x1 | input | 16 | Operand 1, Q1.15 |
| in_x2 | input | 16 | Operand 2, Q1.15 |
| in_x3 | input | 16 | Operand 3, Q1.15 (sine for Park) |
| in_x4 | input | 16 | Operand 4, Q1.15 (cosine for Park) |
| ready | output | 1 | Idle, results valid |
| out_y1 | output | 16 | Result 1 |
| out_y2 | output | 16 | Result 2 |
| out_y3 | output | 16 | Result 3 |
| out_y4 | output | 16 | Result 4 |

## Verification
Two events can fall in the same cycle: the end word of a routine completing, and a new start request. The bench raises `start` on exactly the edge where the end word executes, while `ready` is still 0. It expects that request to be dropped, and expects `ready` to stay high afterwards with the results unchanged. During the same runs the inputs and the selector are scrambled on every busy cycle. Each result is then compared with one computed from the operands captured at acceptance.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int UIW = 12;

  typedef enum logic [2:0] {
    OP_END  = 3'd0,
    OP_MUL  = 3'd1,
    OP_MULK = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_NEG  = 3'd5,
    OP_OUT  = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] dst;
    logic [2:0] sa;
    logic [2:0] sb;
  } uinst_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_EXEC} seq_state_e;

  localparam int K_THIRD = 0;
  localparam int K_ISQ3  = 1;
  localparam int K_HALF  = 2;
  localparam int K_SQ3H  = 3;

  // Q1.15 coefficients
  function automatic logic [15:0] kconst16(input logic [2:0] idx);
    case (idx)
      3'd0:    return 16'd10923;
      3'd1:    return 16'd18919;
      3'd2:    return 16'd16384;
      3'd3:    return 16'd28378;
      default: return 16'd0;
    endcase
  endfunction

  function automatic uinst_t mk(input op_e op, input int d, input int a, input int b);
    uinst_t w;
    w.op  = op;
    w.dst = 3'(d);
    w.sa  = 3'(a);
    w.sb  = 3'(b);
    return w;
  endfunction
endpackage

// File: rtl/ct_rom.sv
module ct_rom
  import ct_pkg::*;
#(
  parameter int DEPTH = 45,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    sel,
  output uinst_t        word,
  output logic [AW-1:0] entry
);
  always_comb begin
    case (sel)
      3'd0:    entry = AW'(0);
      3'd1:    entry = AW'(9);
      3'd2:    entry = AW'(18);
      3'd3:    entry = AW'(27);
      default: entry = AW'(36);
    endcase
  end

  always_comb begin
    case (int'(addr))
      // forward Clarke
      0:  word = mk(OP_SUB,  4, 0, 1);
      1:  word = mk(OP_SUB,  5, 0, 2);
      2:  word = mk(OP_ADD,  4, 4, 5);
      3:  word = mk(OP_MULK, 4, 4, K_THIRD);
      4:  word = mk(OP_SUB,  5, 1, 2);
      5:  word = mk(OP_MULK, 5, 5, K_ISQ3);
      6:  word = mk(OP_OUT,  0, 4, 0);
      7:  word = mk(OP_OUT,  1, 5, 0);
      8:  word = mk(OP_END,  0, 0, 0);
      // reverse Clarke
      9:  word = mk(OP_OUT,  0, 0, 0);
      10: word = mk(OP_MULK, 4, 0, K_HALF);
      11: word = mk(OP_MULK, 5, 1, K_SQ3H);
      12: word = mk(OP_SUB,  6, 5, 4);
      13: word = mk(OP_OUT,  1, 6, 0);
      14: word = mk(OP_NEG,  7, 4, 0);
      15: word = mk(OP_SUB,  6, 7, 5);
      16: word = mk(OP_OUT,  2, 6, 0);
      17: word = mk(OP_END,  0, 0, 0);
      // forward Park
      18: word = mk(OP_MUL,  4, 0, 3);
      19: word = mk(OP_MUL,  5, 1, 2);
      20: word = mk(OP_ADD,  6, 4, 5);
      21: word = mk(OP_OUT,  0, 6, 0);
      22: word = mk(OP_MUL,  4, 1, 3);
      23: word = mk(OP_MUL,  5, 0, 2);
      24: word = mk(OP_SUB,  6, 4, 5);
      25: word = mk(OP_OUT,  1, 6, 0);
      26: word = mk(OP_END,  0, 0, 0);
      // reverse Park
      27: word = mk(OP_MUL,  4, 0, 3);
      28: word = mk(OP_MUL,  5, 1, 2);
      29: word = mk(OP_SUB,  6, 4, 5);
      30: word = mk(OP_OUT,  0, 6, 0);
      31: word = mk(OP_MUL,  4, 0, 2);
      32: word = mk(OP_MUL,  5, 1, 3);
      33: word = mk(OP_ADD,  6, 4, 5);
      34: word = mk(OP_OUT,  1, 6, 0);
      35: word = mk(OP_END,  0, 0, 0);
      default: word = mk(OP_END, 0, 0, 0);
    endcase
  end
endmodule

// File: rtl/ct_alu.sv
module ct_alu
  import ct_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int WW = 2 * DATA_W
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        kidx,
  output logic [DATA_W-1:0] y
);
  localparam logic signed [WW-1:0] MAXV = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [WW-1:0] MINV = ~MAXV;

  function automatic logic signed [WW-1:0] sx(input logic [DATA_W-1:0] v);
    return {{DATA_W{v[DATA_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] clamp(input logic signed [WW-1:0] v);
    if (v > MAXV) return MAXV[DATA_W-1:0];
    if (v < MINV) return MINV[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] qmul(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] z);
    logic signed [WW-1:0] p;
    p = sx(x) * sx(z);
    return clamp(p >>> (DATA_W - 1));
  endfunction

  logic [DATA_W-1:0] kword;
  assign kword = DATA_W'(kconst16(kidx)) << (DATA_W - 16);

  always_comb begin
    case (op)
      OP_MUL:  y = qmul(a, b);
      OP_MULK: y = qmul(a, kword);
      OP_ADD:  y = clamp(sx(a) + sx(b));
      OP_SUB:  y = clamp(sx(a) - sx(b));
      OP_NEG:  y = clamp(-sx(a));
      default: y = a;
    endcase
  end
endmodule

// File: rtl/ct_regfile.sv
module ct_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int NIN    = 4,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NIN-1:0][DATA_W-1:0] load_val,
  input  logic                       we,
  input  logic [RA_W-1:0]            waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [RA_W-1:0]            ra,
  input  logic [RA_W-1:0]            rb,
  output logic [DATA_W-1:0]          qa,
  output logic [DATA_W-1:0]          qb
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] init_v;
    if (g < NIN) begin : g_in
      assign init_v = load_val[g];
    end else begin : g_tmp
      assign init_v = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs[g] <= '0;
      else if (load)                      regs[g] <= init_v;
      else if (we && waddr == RA_W'(g))   regs[g] <= wdata;
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];
endmodule

// File: rtl/ct_seq.sv
module ct_seq
  import ct_pkg::*;
#(
  parameter int DEPTH = 45,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] entry,
  input  uinst_t        rom_word,
  output logic [AW-1:0] pc,
  output uinst_t        ir,
  output logic          ready,
  output logic          accept,
  output logic          fetch_fire,
  output logic          exec_fire,
  output logic          end_fire
);
  seq_state_e state;

  assign accept     = (state == SQ_IDLE) && start;
  assign fetch_fire = (state == SQ_FETCH);
  assign exec_fire  = (state == SQ_EXEC);
  assign end_fire   = exec_fire && (ir.op == OP_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      pc    <= '0;
      ir    <= mk(OP_END, 0, 0, 0);
      ready <= 1'b1;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          pc    <= entry;
          state <= SQ_FETCH;
          ready <= 1'b0;
        end
        SQ_FETCH: begin
          ir    <= rom_word;
          state <= SQ_EXEC;
        end
        SQ_EXEC: begin
          if (ir.op == OP_END) begin
            state <= SQ_IDLE;
            ready <= 1'b1;
          end else begin
            pc    <= pc + AW'(1);
            state <= SQ_FETCH;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clarke_park_unit.sv
module clarke_park_unit
  import ct_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ROM_DEPTH = 45,
  parameter int NREG      = 8,
  parameter int NPORT     = 4,
  localparam int AW       = $clog2(ROM_DEPTH),
  localparam int RA_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        alg_sel,
  input  logic [DATA_W-1:0] in_x1,
  input  logic [DATA_W-1:0] in_x2,
  input  logic [DATA_W-1:0] in_x3,
  input  logic [DATA_W-1:0] in_x4,
  output logic              ready,
  output logic [DATA_W-1:0] out_y1,
  output logic [DATA_W-1:0] out_y2,
  output logic [DATA_W-1:0] out_y3,
  output logic [DATA_W-1:0] out_y4
);
  logic [AW-1:0]     pc, entry;
  uinst_t            rom_word, ir;
  logic              accept, fetch_fire, exec_fire, end_fire;
  logic              alu_we, out_we;
  logic [DATA_W-1:0] qa, qb, alu_y;
  logic [NPORT-1:0][DATA_W-1:0] stage_in;
  logic [DATA_W-1:0] yreg [NPORT];

  assign stage_in = {in_x4, in_x3, in_x2, in_x1};

  ct_rom #(.DEPTH(ROM_DEPTH)) rom_i (
    .addr(pc), .sel(alg_sel), .word(rom_word), .entry(entry)
  );

  ct_seq #(.DEPTH(ROM_DEPTH)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .entry(entry),
    .rom_word(rom_word), .pc(pc), .ir(ir), .ready(ready),
    .accept(accept), .fetch_fire(fetch_fire), .exec_fire(exec_fire),
    .end_fire(end_fire)
  );

  always_comb begin
    case (ir.op)
      OP_MUL, OP_MULK, OP_ADD, OP_SUB, OP_NEG: alu_we = exec_fire;
      default:                                 alu_we = 1'b0;
    endcase
  end
  assign out_we = exec_fire && (ir.op == OP_OUT);

  ct_regfile #(.DATA_W(DATA_W), .NREG(NREG), .NIN(NPORT)) rf_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(stage_in),
    .we(alu_we), .waddr(RA_W'(ir.dst)), .wdata(alu_y),
    .ra(RA_W'(ir.sa)), .rb(RA_W'(ir.sb)), .qa(qa), .qb(qb)
  );

  ct_alu #(.DATA_W(DATA_W)) alu_i (
    .op(ir.op), .a(qa), .b(qb), .kidx(ir.sb), .y(alu_y)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              yreg[g] <= '0;
      else if (accept)                         yreg[g] <= '0;
      else if (out_we && ir.dst == 3'(g))      yreg[g] <= qa;
    end
  end

  assign out_y1 = yreg[0];
  assign out_y2 = yreg[1];
  assign out_y3 = yreg[2];
  assign out_y4 = yreg[3];
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int DATA_W    = 16,
  parameter int ROM_DEPTH = 45,
  localparam int AW       = $clog2(ROM_DEPTH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                ready,
  input logic                accept,
  input logic                fetch_fire,
  input logic                exec_fire,
  input logic                end_fire,
  input logic [AW-1:0]       pc,
  input logic [4*DATA_W-1:0] outs
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R2
  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && start && !end_fire) |=> !ready); // R2
  AST_END_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    end_fire |=> ready); // R3
  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (outs == '0)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(outs)); // R4
  AST_EXEC_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |-> $past(fetch_fire)); // R11
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_fire, exec_fire, ready})); // R11
  AST_PC_IN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pc) < ROM_DEPTH); // R11
endmodule

bind clarke_park_unit ct_checker #(.DATA_W(DATA_W), .ROM_DEPTH(ROM_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .accept(accept),
  .fetch_fire(fetch_fire), .exec_fire(exec_fire), .end_fire(end_fire),
  .pc(pc), .outs({out_y4, out_y3, out_y2, out_y1})
);

// File: tb/clarke_park_unit_tb_top.sv
`timescale 1ns/1ps
module clarke_park_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [15:0] xin [4];
  logic ready;
  logic [15:0] y1, y2, y3, y4;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  bit      m_ready = 1;
  int      m_cnt = 0;
  longint  m_out [4];
  string   m_tag = "R1";

  always #10 clk = ~clk;

  clarke_park_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(sel),
    .in_x1(xin[0]), .in_x2(xin[1]), .in_x3(xin[2]), .in_x4(xin[3]),
    .ready(ready), .out_y1(y1), .out_y2(y2), .out_y3(y3), .out_y4(y4)
  );

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint qm(longint x, longint z);
    longint p = x * z;
    longint f = (p >= 0) ? (p / 32768) : -((-p + 32767) / 32768);
    return sat(f);
  endfunction

  function automatic longint sv(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic compute(input logic [2:0] s);
    longint a = sv(xin[0]), b = sv(xin[1]), c = sv(xin[2]), d = sv(xin[3]);
    longint u, h, k;
    for (int i = 0; i < 4; i++) m_out[i] = 0;
    case (s)
      3'd0: begin
        u = sat(sat(a - b) + sat(a - c));
        m_out[0] = qm(u, 10923);
        m_out[1] = qm(sat(b - c), 18919);
      end
      3'd1: begin
        h = qm(a, 16384);
        k = qm(b, 28378);
        m_out[0] = a;
        m_out[1] = sat(k - h);
        m_out[2] = sat(sat(-h) - k);
      end
      3'd2: begin
        m_out[0] = sat(qm(a, d) + qm(b, c));
        m_out[1] = sat(qm(b, d) - qm(a, c));
      end
      3'd3: begin
        m_out[0] = sat(qm(a, d) - qm(b, c));
        m_out[1] = sat(qm(a, c) + qm(b, d));
      end
      default: ;
    endcase
  endtask

  task automatic model_edge();
    if (!rst_n) return;
    if (!m_ready) begin
      m_cnt--;
      if (m_cnt == 0) m_ready = 1;
    end else if (start) begin
      compute(sel);
      m_ready = 0;
      m_cnt = (sel < 3'd4) ? 18 : 2;
    end
  endtask

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] ys [4];
    ys[0] = y1; ys[1] = y2; ys[2] = y3; ys[3] = y4;
    chk(ready === m_ready, {m_tag, " ready timing R3/R11"}, longint'(ready), longint'(m_ready));
    if (m_ready)
      for (int i = 0; i < 4; i++)
        chk(sv(ys[i]) == m_out[i], $sformatf("%s y%0d", m_tag, i + 1), sv(ys[i]), m_out[i]);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  // disturb: scramble inputs/selector while busy and pulse start on the final edge
  task automatic run_op(input logic [2:0] s, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] c, input logic [15:0] d, input bit disturb,
                        input string tag);
    sel = s;
    xin[0] = a; xin[1] = b; xin[2] = c; xin[3] = d;
    start = 1'b1;
    step();
    m_tag = disturb ? {"R10 R2 ", tag} : tag;
    start = 1'b0;
    while (!m_ready) begin
      if (disturb) begin
        for (int i = 0; i < 4; i++) xin[i] = 16'($urandom);
        sel = 3'($urandom);
        start = (m_cnt == 1) ? 1'b1 : 1'($urandom);
      end
      step();
    end
    start = 1'b0;
    m_tag = {"R4 hold ", tag};
    step();
    step();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      xin[i] = '0;
      m_out[i] = 0;
    end
    repeat (3) @(negedge clk);
    compare();                 // R1 state while in reset
    rst_n = 1'b1;
    step();                    // R1 after release
    step();

    run_op(3'd0, 16'd8000, 16'hF000, 16'h0800, 16'd0, 0, "R6 fwd clarke");
    run_op(3'd1, 16'd12000, 16'hE000, 16'd0, 16'd0, 0, "R7 rev clarke");
    run_op(3'd2, 16'd10000, 16'hD8F0, 16'd23170, 16'd23170, 0, "R8 fwd park");
    run_op(3'd3, 16'd9000, 16'd4000, 16'hC000, 16'd28378, 0, "R9 rev park");
    run_op(3'd5, 16'd1234, 16'd1, 16'd2, 16'd3, 0, "R3 R4 unsupported code");
    run_op(3'd0, 16'h7FFF, 16'h8000, 16'h8000, 16'd0, 0, "R5 R6 saturating clarke");
    run_op(3'd2, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 0, "R5 R8 saturating park");
    run_op(3'd3, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 0, "R5 R9 min operands");
    run_op(3'd1, 16'h8000, 16'h8000, 16'd0, 16'd0, 0, "R5 R7 min operands");
    run_op(3'd2, 16'd5000, 16'hEC78, 16'hF000, 16'd30000, 1, "R8 fwd park");
    run_op(3'd0, 16'hC000, 16'd3000, 16'd700, 16'd0, 1, "R6 fwd clarke");
    run_op(3'd7, 16'd1, 16'd1, 16'd1, 16'd1, 1, "R3 R4 unsupported code");
    for (int n = 0; n < 8; n++)
      run_op(3'(n % 4), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             bit'(n % 2), "R5 R6 R7 R8 R9 mixed");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule